// File: doc/BRIEF.md
# Per-Line Input Pulse Filter Bank

This block conditions a bank of input lines before their values reach the pin-data readback and the input-change detector. Each line first crosses into the controller clock domain through a short synchronizer. It can then go straight to the readback, or pass through a filter that drops short pulses. The value sent to peripheral functions is never filtered. It is the raw pin.

A per-line enable bit turns the filter on or off, and a per-line mode bit picks its flavour. Mode 0 is a glitch rejector that samples on every controller clock. Mode 1 is a debouncer that samples on a divided slow-clock tick. The divider counts slow-clock edges, which arrive as one-cycle strobes in the controller domain. It issues a tick every 2×(DIV+1) strobes. Both the enable word and the mode word change only through write-one-to-set and write-one-to-clear strobes. Software never writes the words directly.

In both modes the filter is a two-sample agreement stage. The output takes the synchronized value only when two consecutive samples, taken on the selected tick, agree. A clock-enable input stands in for the controller clock being gated. While it is low, the synchronizer, the filters, the divider and the change detector all hold still.

Top module: `pin_filter_bank`

## Requirements
- R1: For every bit at 1 in `flt_set_i`, the matching bit of `flt_en_o` is 1 after the next clock edge. The same holds for `mode_set_i` and `mode_o`. Bits at 0 in any strobe leave their status bits unchanged.
- R2: For every bit at 1 in `flt_clr_i`, the matching bit of `flt_en_o` is 0 after the next clock edge. When a set and a clear hit the same bit in the same cycle, the clear wins. `mode_clr_i` behaves the same way for `mode_o`.
- R3: A `mode_o` bit of 0 selects the glitch filter on that line, and a bit of 1 selects the debouncer. The mode has no effect while the line's enable bit is 0.
- R4: `periph_o` always equals `pin_i`, with no delay and no filtering, whatever the enable and mode settings.
- R5: With a line's filter disabled, `data_o` shows a pin change exactly two clock edges after the pin changes.
- R6: In glitch mode, a pin pulse one clock cycle wide never reaches `data_o`.
- R7: In glitch mode, a pin level held for two or more cycles reaches `data_o` exactly four clock edges after the pin changes. That is two edges more than with the filter disabled.
- R8: In debounce mode, `data_o` changes only on a divider tick, and only after two consecutive tick samples agree. A pulse shorter than one divided period is rejected. A level held for two or more divided periods is passed.
- R9: The divider tick comes every 2×(`div_i`+1) slow-clock strobes. So with `div_i`=2, a debounced change can appear no earlier than eight clock edges after the pin change when strobes come on every cycle.
- R10: While `clk_en_i` is 0, `data_o` does not follow the pin. Once `clk_en_i` returns to 1, a disabled line shows the pin two edges later.
- R11: `chg_o` is 1 for exactly one cycle on each line whose `data_o` has just changed, and 0 otherwise while `clk_en_i` is 1.
- R12: After reset, the enable and mode words are 0, `data_o` is 0 for a low pin, and `chg_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Controller clock running; 0 freezes the filtering path |
| slow_tick_i | input | 1 | One-cycle strobe per slow-clock edge |
| div_i | input | DIV_W | Debounce divider value DIV |
| flt_set_i | input | N_LINES | Write-one-to-set strobe for filter enables |
| flt_clr_i | input | N_LINES | Write-one-to-clear strobe for filter enables |
| mode_set_i | input | N_LINES | Write-one-to-set strobe for the mode bits (1 = debounce) |
| mode_clr_i | input | N_LINES | Write-one-to-clear strobe for the mode bits |
| pin_i | input | N_LINES | Raw pin levels |
| periph_o | output | N_LINES | Unfiltered pin value for peripheral functions |
| data_o | output | N_LINES | Pin-data readback value, filtered where enabled |
| chg_o | output | N_LINES | Per-line one-cycle input-change pulse |
| flt_en_o | output | N_LINES | Filter enable word |
| mode_o | output | N_LINES | Filter mode word |

## Verification
The bench drives a single-cycle pulse and a two-cycle pulse into a glitch-mode line. The first must vanish and the second must appear, which pins down the rejection boundary and the four-edge latency. The same pulses go into a disabled line at the same moment, which separates pass-through from filtering.

Debounce lines get pulses just shorter than one divided period and levels lasting many periods. The test runs at two divider values. It checks an early cycle where a mis-divided or wrongly-moded filter would already have switched. Pin changes made while the clock enable is low show whether the path freezes and how it resumes.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

   typedef enum logic {
      MODE_GLITCH   = 1'b0,
      MODE_DEBOUNCE = 1'b1
   } flt_mode_e;

   // Terminal count of the divider: 2*(div+1) strobes means counts 0 .. 2*div+1
   function automatic int unsigned div_limit(input int unsigned div);
      return 2 * div + 1;
   endfunction

endpackage

// File: rtl/pfb_set_clr_reg.sv
module pfb_set_clr_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= '0;
      else        state_q <= (state_q | set_i) & ~clr_i;
   end

   assign q_o = state_q;

   // R1: set strobes take effect unless cleared in the same cycle
   a_r1_set_applies: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

   // R2: clear strobes always win
   a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_o & $past(clr_i)) == '0));

   // R1: bits with zero strobes are untouched
   a_r1_zero_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((q_o ^ $past(q_o)) & ~$past(set_i | clr_i)) == '0));

endmodule

// File: rtl/pfb_sync.sv
module pfb_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stg_q [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic [W-1:0] src;
      if (k == 0) begin : g_first
         assign src = d_i;
      end else begin : g_next
         assign src = stg_q[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     stg_q[k] <= '0;
         else if (run_i) stg_q[k] <= src;
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pfb_divider.sv
module pfb_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             slow_tick_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             div_tick_o
);

   localparam int CW = DIV_W + 1;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;
   logic          step;

   assign limit      = CW'(pfb_pkg::div_limit(int'(div_i)));
   assign step       = run_i && slow_tick_i;
   assign div_tick_o = step && (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (div_tick_o) cnt_q <= '0;
      else if (step)       cnt_q <= cnt_q + 1'b1;
   end

   // R9: between ticks the count advances by one per slow strobe
   a_r9_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !div_tick_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R9: after a tick the period restarts
   a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      div_tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/pfb_line_filter.sv
module pfb_line_filter
   import pfb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic en_i,
   input  logic mode_i,
   input  logic div_tick_i,
   input  logic pin_s_i,
   output logic data_o
);

   flt_mode_e mode;
   logic      smp_q;
   logic      filt_q;
   logic      tick;

   assign mode = flt_mode_e'(mode_i);
   assign tick = run_i && ((mode == MODE_GLITCH) ? 1'b1 : div_tick_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q  <= 1'b0;
         filt_q <= 1'b0;
      end else if (run_i && !en_i) begin
         smp_q  <= pin_s_i;
         filt_q <= pin_s_i;
      end else if (tick) begin
         smp_q <= pin_s_i;
         if (smp_q == pin_s_i) filt_q <= pin_s_i;
      end
   end

   assign data_o = en_i ? filt_q : pin_s_i;

   // R6/R8: while filtering, the output moves only on a tick with two agreeing samples
   a_r8_change_on_agreed_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && $past(en_i) && (filt_q != $past(filt_q)))
         |-> ($past(tick) && ($past(smp_q) == filt_q) && ($past(pin_s_i) == filt_q)));

endmodule

// File: rtl/pin_filter_bank.sv
module pin_filter_bank #(
   parameter int N_LINES     = 32,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_en_i,
   input  logic               slow_tick_i,
   input  logic [DIV_W-1:0]   div_i,
   input  logic [N_LINES-1:0] flt_set_i,
   input  logic [N_LINES-1:0] flt_clr_i,
   input  logic [N_LINES-1:0] mode_set_i,
   input  logic [N_LINES-1:0] mode_clr_i,
   input  logic [N_LINES-1:0] pin_i,
   output logic [N_LINES-1:0] periph_o,
   output logic [N_LINES-1:0] data_o,
   output logic [N_LINES-1:0] chg_o,
   output logic [N_LINES-1:0] flt_en_o,
   output logic [N_LINES-1:0] mode_o
);

   if (N_LINES < 1 || N_LINES > 1024) begin : g_bad_lines
      $error("pin_filter_bank: N_LINES out of range");
   end
   if (DIV_W < 1 || DIV_W > 30) begin : g_bad_div
      $error("pin_filter_bank: DIV_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pin_filter_bank: SYNC_STAGES must be at least 2");
   end

   logic [N_LINES-1:0] pin_s;
   logic [N_LINES-1:0] prev_q;
   logic               div_tick;

   assign periph_o = pin_i;

   pfb_set_clr_reg #(.W(N_LINES)) u_en_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flt_set_i),
      .clr_i (flt_clr_i),
      .q_o   (flt_en_o)
   );

   pfb_set_clr_reg #(.W(N_LINES)) u_mode_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (mode_set_i),
      .clr_i (mode_clr_i),
      .q_o   (mode_o)
   );

   pfb_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (clk_en_i),
      .d_i   (pin_i),
      .q_o   (pin_s)
   );

   pfb_divider #(.DIV_W(DIV_W)) u_div (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (clk_en_i),
      .slow_tick_i (slow_tick_i),
      .div_i       (div_i),
      .div_tick_o  (div_tick)
   );

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      pfb_line_filter u_flt (
         .clk        (clk),
         .rst_n      (rst_n),
         .run_i      (clk_en_i),
         .en_i       (flt_en_o[i]),
         .mode_i     (mode_o[i]),
         .div_tick_i (div_tick),
         .pin_s_i    (pin_s[i]),
         .data_o     (data_o[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prev_q <= '0;
      else if (clk_en_i) prev_q <= data_o;
   end

   assign chg_o = clk_en_i ? (data_o ^ prev_q) : '0;

   // R10: a stopped controller clock freezes the synchronized pin
   a_r10_sync_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en_i |=> $stable(pin_s));

   // R11: a change pulse never lasts two cycles on an unchanged value
   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en_i && $past(clk_en_i) && $stable(data_o)) |-> (chg_o == '0));

endmodule

// File: tb/pin_filter_bank_bench.sv
module pin_filter_bank_bench;

   localparam int N = 32;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en_i = 1'b1;
   logic          slow_tick_i = 1'b0;
   logic [DW-1:0] div_i = '0;
   logic [N-1:0]  flt_set_i = '0, flt_clr_i = '0, mode_set_i = '0, mode_clr_i = '0;
   logic [N-1:0]  pin_i = '0;
   logic [N-1:0]  periph_o, data_o, chg_o, flt_en_o, mode_o;

   pin_filter_bank #(.N_LINES(N), .DIV_W(DW), .SYNC_STAGES(2)) u_pin_filter_bank (
      .clk, .rst_n, .clk_en_i, .slow_tick_i, .div_i,
      .flt_set_i, .flt_clr_i, .mode_set_i, .mode_clr_i, .pin_i,
      .periph_o, .data_o, .chg_o, .flt_en_o, .mode_o
   );

   always #5 clk = ~clk;

   typedef struct {
      int          cyc;
      logic [N-1:0] msk;
      logic [N-1:0] val;
      int          sel;
      string       req;
   } item_t;

   item_t        sb_q[$];
   int           cyc = 0;
   int           n_cmp = 0;
   int           n_bad = 0;
   logic [N-1:0] act;

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compare queued expectations away from the active edge
   always @(negedge clk) begin
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
         if (sb_q[i].cyc <= cyc) begin
            act = (sb_q[i].sel != 0) ? chg_o : data_o;
            n_cmp++;
            if (sb_q[i].cyc < cyc || (act & sb_q[i].msk) != sb_q[i].val) begin
               n_bad++;
               $display("FAIL %s cyc %0d: actual %h expected %h (mask %h)",
                        sb_q[i].req, cyc, act & sb_q[i].msk, sb_q[i].val, sb_q[i].msk);
            end
            sb_q.delete(i);
         end
      end
   end

   task automatic exp_at(int d, logic [N-1:0] m, logic [N-1:0] v, int sel, string r);
      item_t it;
      it.cyc = cyc + d; it.msk = m; it.val = v & m; it.sel = sel; it.req = r;
      sb_q.push_back(it);
   endtask

   task automatic chk(string r, logic [N-1:0] a, logic [N-1:0] e);
      n_cmp++;
      if (a !== e) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", r, a, e);
      end
   endtask

   task automatic step(int n);
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      step(3);
      // R12: reset state
      chk("R12 flt_en", flt_en_o, '0);
      chk("R12 mode", mode_o, '0);
      chk("R12 data", data_o, '0);
      chk("R12 chg", chg_o, '0);
      rst_n = 1'b1;
      step(3);

      // R4 / R5 / R11: pass-through with filters off
      pin_i = 32'hA5A5_0F0F;
      #1 chk("R4 periph raw", periph_o, 32'hA5A5_0F0F);
      exp_at(1, '1, 32'h0, 0, "R5 not yet");
      exp_at(2, '1, 32'hA5A5_0F0F, 0, "R5 two edges");
      exp_at(2, '1, 32'hA5A5_0F0F, 1, "R11 pulse");
      exp_at(3, '1, 32'h0, 1, "R11 one cycle");
      step(4);
      pin_i = '0;
      step(5);

      // R1 / R2 / R3: set and clear strobes
      flt_set_i = 32'h0000_00F0; step(1); flt_set_i = '0;
      chk("R1 set", flt_en_o, 32'h0000_00F0);
      flt_set_i = 32'h0000_0100; step(1); flt_set_i = '0;
      chk("R1 zero bits kept", flt_en_o, 32'h0000_01F0);
      flt_set_i = 32'h0000_0200; flt_clr_i = 32'h0000_0200; step(1);
      flt_set_i = '0; flt_clr_i = '0;
      chk("R2 clear wins", flt_en_o, 32'h0000_01F0);
      flt_clr_i = 32'h0000_0010; step(1); flt_clr_i = '0;
      chk("R2 clear", flt_en_o, 32'h0000_01E0);
      mode_set_i = 32'h0000_0300; step(1); mode_set_i = '0;
      chk("R3 mode set", mode_o, 32'h0000_0300);
      mode_clr_i = 32'h0000_0200; step(1); mode_clr_i = '0;
      chk("R3 mode clear", mode_o, 32'h0000_0100);
      #1 chk("R4 periph under filter", periph_o, pin_i);
      step(4);

      // R6: one-cycle pulse on glitch line 5 and disabled line 0
      pin_i = 32'h0000_0021;
      exp_at(2, 32'h1, 32'h1, 0, "R5 off line sees pulse");
      exp_at(3, 32'h1, 32'h0, 0, "R5 off line pulse ends");
      for (int d = 1; d <= 6; d++) exp_at(d, 32'h20, 32'h0, 0, "R6 glitch rejected");
      step(1);
      pin_i = '0;
      step(8);

      // R7: two-cycle pulse on glitch line 6
      pin_i = 32'h0000_0040;
      exp_at(3, 32'h40, 32'h0, 0, "R7 not yet");
      exp_at(4, 32'h40, 32'h40, 0, "R7 passed");
      exp_at(5, 32'h40, 32'h40, 0, "R7 held");
      exp_at(6, 32'h40, 32'h0, 0, "R7 falls");
      exp_at(4, 32'h40, 32'h40, 1, "R11 filtered change");
      step(2);
      pin_i = '0;
      step(8);

      // R10: gated clock freezes the path
      clk_en_i = 1'b0;
      pin_i = 32'h0000_0003;
      for (int d = 1; d <= 5; d++) exp_at(d, 32'h3, 32'h0, 0, "R10 frozen");
      step(6);
      clk_en_i = 1'b1;
      exp_at(1, 32'h3, 32'h0, 0, "R10 resume wait");
      exp_at(2, 32'h3, 32'h3, 0, "R10 resumed");
      step(4);
      pin_i = '0;
      step(6);

      // R8 / R9: debounce on line 8 with div 0, strobe every cycle
      slow_tick_i = 1'b1;
      div_i = 8'd0;
      step(6);
      pin_i = 32'h0000_0100;
      for (int d = 1; d <= 10; d++) exp_at(d, 32'h100, 32'h0, 0, "R8 short pulse rejected");
      step(1);
      pin_i = '0;
      step(12);
      pin_i = 32'h0000_0100;
      exp_at(4, 32'h100, 32'h0, 0, "R8 not before tick pair");
      exp_at(10, 32'h100, 32'h100, 0, "R8 long level passed");
      step(12);
      pin_i = '0;
      step(14);

      // R9: div 2 gives a six-strobe period
      div_i = 8'd2;
      step(20);
      pin_i = 32'h0000_0100;
      for (int d = 1; d <= 14; d++) exp_at(d, 32'h100, 32'h0, 0, "R9 sub-period pulse rejected");
      step(5);
      pin_i = '0;
      step(20);
      pin_i = 32'h0000_0100;
      exp_at(7, 32'h100, 32'h0, 0, "R9 no early change");
      exp_at(8, 32'h100, 32'h0, 0, "R9 no early change");
      exp_at(25, 32'h100, 32'h100, 0, "R9 long level passed");
      step(40);
      pin_i = '0;
      step(30);

      wait (sb_q.size() == 0);
      step(2);
      finish_run();
   end

endmodule